// File: doc/BRIEF.md
# Debug Mode Entry Controller with Instruction Injection

This block sits beside a processor core and governs its halted debug state. Eight event lines report why the core should stop: a request or an abort from the attached tool, a program-counter or data breakpoint, a breakpoint instruction, the all-zero trap opcode, a single-step completion, or a pulse on an external event pin. When debugging is enabled and not masked, any such event moves the core into debug mode. Every event present in that cycle is recorded in a sticky flag register, and the core receives a one-cycle entry strobe.

While the core is halted, the tool pushes 32-bit words into an injection port. The block cuts each word into two 16-bit parcels, upper half first. It rebuilds compact 16-bit opcodes and extended 32-bit opcodes from them, and an extended opcode may start in the low half of one word and finish in the high half of the next. Opcodes go to the core over a valid/ready pair. A done flag reports when the core has taken every complete opcode of the last word. When the core accepts the return opcode 0xD623, debug mode ends.

Top module: `dbg_entry_inject`

## Requirements
- R1: `dbg_mode` rises on the clock edge that samples `dbg_en`=1, `dbg_mask`=0 and at least one `cause_evt` bit high while not already in debug mode. Events sampled at any other time leave `dbg_mode` and `cause_flags` unchanged.
- R2: `cause_evt` bit i sets `cause_flags` bit i on entry. Bit order: 0 tool request, 1 PC breakpoint, 2 data breakpoint, 3 breakpoint instruction, 4 zero-opcode trap, 5 single step, 6 external event, 7 tool abort. All bits high together are recorded together.
- R3: Flags stay set until a cycle with `flag_clr_we`=1 clears exactly the bits that are one in `flag_clr_mask`.
- R4: `dbg_enter` is high for exactly the first cycle in which `dbg_mode` is high.
- R5: `sw_dbit_wr` sets `sr_dbit` without entering debug mode. `sr_dbit` also sets on entry and clears on exit.
- R6: A word is split into parcels in the order [31:16] then [15:0]. A parcel with bits [15:13]=111 starts an extended opcode, and `op_data` holds the first parcel in [31:16] and the second in [15:0], with `op_is32`=1. Any other parcel is presented as a 16-bit opcode, zero-extended, with `op_is32`=0. A leading extended half in the low parcel is joined to the high parcel of the next word.
- R7: `inj_done` clears on the edge that accepts a word. It sets once every complete opcode of that word has been accepted, and it reads 1 after reset.
- R8: `inj_ready` is high only in debug mode with no parcel of the previous word still pending.
- R9: Accepting the 16-bit opcode 0xD623 leaves debug mode and discards the remaining parcels and any held extended half.
- R10: While `op_valid` is high and `op_ready` is low, `op_valid` and `op_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug facility enabled |
| dbg_mask | input | 1 | Debug entry masked |
| cause_evt | input | 8 | Entry cause events, one per bit |
| sw_dbit_wr | input | 1 | Privileged software write of the status debug bit |
| flag_clr_we | input | 1 | Write-one-to-clear strobe for cause flags |
| flag_clr_mask | input | 8 | Cause flag bits to clear |
| inj_valid | input | 1 | Injection word offered |
| inj_data | input | 32 | Injection word |
| inj_ready | output | 1 | Injection word can be taken |
| op_valid | output | 1 | Opcode offered to core |
| op_data | output | 32 | Opcode, 16-bit opcodes in [15:0] |
| op_is32 | output | 1 | Offered opcode is extended |
| op_ready | input | 1 | Core takes the opcode |
| dbg_mode | output | 1 | Core is in debug mode |
| dbg_enter | output | 1 | One-cycle entry strobe |
| cause_flags | output | 8 | Sticky cause flags |
| sr_dbit | output | 1 | Status-register debug bit |
| inj_done | output | 1 | All opcodes of last word consumed |

## Verification
The injector is driven with words holding two compact opcodes, with a word whose extended opcode straddles into the next word, with a word holding one whole extended opcode, and with a word that starts with the return opcode and is followed by an extended half. Together these separate correct parcel order from swapped halves, a proper join across words from a lost or stale half, and a clean discard on exit. Entry is tried with the facility disabled, masked, with several causes in one cycle, and with causes that arrive while already halted. A long run of random words with a random core-ready pattern is compared, cycle by cycle, against a queue-based model.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int NUM_CAUSE = 8;
  localparam int EXT_MARK_W = 3;
  localparam logic [15:0] RETURN_OP = 16'hD623;

  typedef enum int {
    CZ_TOOL_REQ   = 0,
    CZ_PC_BRK     = 1,
    CZ_DATA_BRK   = 2,
    CZ_BRK_INSN   = 3,
    CZ_ZERO_TRAP  = 4,
    CZ_STEP       = 5,
    CZ_EXT_EVENT  = 6,
    CZ_TOOL_ABORT = 7
  } cause_idx_e;
endpackage

// File: rtl/dbg_entry_ctl.sv
module dbg_entry_ctl #(
  parameter int NCAUSE = dbg_pkg::NUM_CAUSE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              dbg_mask,
  input  logic [NCAUSE-1:0] cause_evt,
  input  logic              sw_dbit_wr,
  input  logic              flag_clr_we,
  input  logic [NCAUSE-1:0] flag_clr_mask,
  input  logic              exit_req,
  output logic              dbg_mode,
  output logic              dbg_enter,
  output logic [NCAUSE-1:0] cause_flags,
  output logic              sr_dbit
);
  logic              mode_q, mode_d;
  logic              enter_q, enter_d;
  logic [NCAUSE-1:0] flags_q, flags_d;
  logic              sr_q, sr_d;
  logic              entry;
  logic [NCAUSE-1:0] clr_bits;

  always_comb begin
    entry    = !mode_q && dbg_en && !dbg_mask && (|cause_evt);
    clr_bits = flag_clr_we ? flag_clr_mask : '0;
    flags_d  = (flags_q & ~clr_bits) | (entry ? cause_evt : '0);
    enter_d  = entry;
    mode_d   = mode_q;
    if (entry) mode_d = 1'b1;
    else if (exit_req) mode_d = 1'b0;
    sr_d = sr_q;
    if (exit_req) sr_d = 1'b0;
    else if (entry || sw_dbit_wr) sr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      enter_q <= 1'b0;
      flags_q <= '0;
      sr_q    <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      enter_q <= enter_d;
      flags_q <= flags_d;
      sr_q    <= sr_d;
    end
  end

  assign dbg_mode    = mode_q;
  assign dbg_enter   = enter_q;
  assign cause_flags = flags_q;
  assign sr_dbit     = sr_q;
endmodule

// File: rtl/dbg_inject.sv
module dbg_inject #(
  parameter int IW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_mode,
  input  logic          inj_valid,
  input  logic [IW-1:0] inj_data,
  output logic          inj_ready,
  output logic          op_valid,
  output logic [2*PW-1:0] op_data,
  output logic          op_is32,
  input  logic          op_ready,
  output logic          inj_done,
  output logic          exit_req
);
  localparam int NPARC = IW / PW;
  localparam int CW    = $clog2(NPARC + 1);
  localparam int OW    = 2 * PW;

  logic [IW-1:0] word_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_v_q, hold_v_d;
  logic [PW-1:0] hold_q, hold_d;
  logic          done_q, done_d;
  logic [PW-1:0] parc [NPARC];
  logic [PW-1:0] cur, nxt;
  logic          cur_ext, spill, accept, wr;
  logic [CW-1:0] take;
  logic          v_c, x_c;
  logic [OW-1:0] d_c;

  for (genvar g = 0; g < NPARC; g++) begin : g_parc
    assign parc[g] = word_q[IW-1-g*PW -: PW];
  end

  always_comb begin
    cur = '0;
    nxt = '0;
    for (int i = 0; i < NPARC; i++) begin
      if (int'(cnt_q) == NPARC - i) cur = parc[i];
      if (int'(cnt_q) == NPARC - i + 1) nxt = parc[i];
    end
    cur_ext = &cur[PW-1 -: dbg_pkg::EXT_MARK_W];
    v_c = 1'b0; x_c = 1'b0; d_c = '0; take = '0; spill = 1'b0;
    if (cnt_q != '0) begin
      if (hold_v_q) begin
        v_c = 1'b1; x_c = 1'b1; d_c = {hold_q, cur}; take = CW'(1);
      end else if (cur_ext) begin
        if (cnt_q >= CW'(2)) begin
          v_c = 1'b1; x_c = 1'b1; d_c = {cur, nxt}; take = CW'(2);
        end else begin
          spill = 1'b1;
        end
      end else begin
        v_c = 1'b1; d_c = {{PW{1'b0}}, cur}; take = CW'(1);
      end
    end
  end

  assign inj_ready = dbg_mode && (cnt_q == '0);
  assign wr        = inj_valid && inj_ready;
  assign accept    = v_c && op_ready;
  assign exit_req  = accept && !x_c && (d_c[PW-1:0] == PW'(dbg_pkg::RETURN_OP));

  always_comb begin
    cnt_d    = cnt_q;
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    if (exit_req) begin
      cnt_d    = '0;
      hold_v_d = 1'b0;
    end else if (wr) begin
      cnt_d = CW'(NPARC);
    end else if (accept) begin
      cnt_d = cnt_q - take;
      if (hold_v_q) hold_v_d = 1'b0;
    end else if (spill) begin
      hold_d   = cur;
      hold_v_d = 1'b1;
      cnt_d    = cnt_q - CW'(1);
    end
    done_d = done_q;
    if (wr) done_d = 1'b0;
    else if (cnt_d == '0) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      cnt_q    <= '0;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      done_q   <= 1'b1;
    end else begin
      if (wr) word_q <= inj_data;
      if (spill && !exit_req) hold_q <= hold_d;
      cnt_q    <= cnt_d;
      hold_v_q <= hold_v_d;
      done_q   <= done_d;
    end
  end

  assign op_valid = v_c;
  assign op_data  = d_c;
  assign op_is32  = x_c;
  assign inj_done = done_q;
endmodule

// File: rtl/dbg_entry_inject.sv
module dbg_entry_inject #(
  parameter int NCAUSE = dbg_pkg::NUM_CAUSE,
  parameter int IW     = 32,
  parameter int PW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              dbg_mask,
  input  logic [NCAUSE-1:0] cause_evt,
  input  logic              sw_dbit_wr,
  input  logic              flag_clr_we,
  input  logic [NCAUSE-1:0] flag_clr_mask,
  input  logic              inj_valid,
  input  logic [IW-1:0]     inj_data,
  output logic              inj_ready,
  output logic              op_valid,
  output logic [2*PW-1:0]   op_data,
  output logic              op_is32,
  input  logic              op_ready,
  output logic              dbg_mode,
  output logic              dbg_enter,
  output logic [NCAUSE-1:0] cause_flags,
  output logic              sr_dbit,
  output logic              inj_done
);
  logic exit_req;

  dbg_entry_ctl #(.NCAUSE(NCAUSE)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_en        (dbg_en),
    .dbg_mask      (dbg_mask),
    .cause_evt     (cause_evt),
    .sw_dbit_wr    (sw_dbit_wr),
    .flag_clr_we   (flag_clr_we),
    .flag_clr_mask (flag_clr_mask),
    .exit_req      (exit_req),
    .dbg_mode      (dbg_mode),
    .dbg_enter     (dbg_enter),
    .cause_flags   (cause_flags),
    .sr_dbit       (sr_dbit)
  );

  dbg_inject #(.IW(IW), .PW(PW)) u_inj (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_mode  (dbg_mode),
    .inj_valid (inj_valid),
    .inj_data  (inj_data),
    .inj_ready (inj_ready),
    .op_valid  (op_valid),
    .op_data   (op_data),
    .op_is32   (op_is32),
    .op_ready  (op_ready),
    .inj_done  (inj_done),
    .exit_req  (exit_req)
  );
endmodule

// File: rtl/dbg_entry_inject_chk.sv
module dbg_entry_inject_chk #(
  parameter int NCAUSE = 8,
  parameter int OW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_en,
  input logic              dbg_mask,
  input logic [NCAUSE-1:0] cause_evt,
  input logic              sw_dbit_wr,
  input logic              flag_clr_we,
  input logic              inj_ready,
  input logic              op_valid,
  input logic [OW-1:0]     op_data,
  input logic              op_is32,
  input logic              op_ready,
  input logic              dbg_mode,
  input logic              dbg_enter,
  input logic [NCAUSE-1:0] cause_flags
);
  AST_ENTRY_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_mode) |-> $past(dbg_en && !dbg_mask && (|cause_evt))); // R1

  AST_CAUSES_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_mode) |-> ((cause_flags & $past(cause_evt)) == $past(cause_evt))); // R2

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_clr_we) |-> ((~cause_flags & $past(cause_flags)) == '0)); // R3

  AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |=> !dbg_enter); // R4

  AST_ENTER_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |-> dbg_mode); // R4

  AST_SW_BIT_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_dbit_wr && !dbg_mode && !(dbg_en && !dbg_mask && (|cause_evt))) |=> !dbg_mode); // R5

  AST_NO_INJECT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_mode |-> (!inj_ready && !op_valid)); // R8

  AST_RETURN_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_is32 && op_data[15:0] == 16'hD623) |=> !dbg_mode); // R9

  AST_OP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_data))); // R10
endmodule

bind dbg_entry_inject dbg_entry_inject_chk #(.NCAUSE(NCAUSE), .OW(2*PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dbg_en      (dbg_en),
  .dbg_mask    (dbg_mask),
  .cause_evt   (cause_evt),
  .sw_dbit_wr  (sw_dbit_wr),
  .flag_clr_we (flag_clr_we),
  .inj_ready   (inj_ready),
  .op_valid    (op_valid),
  .op_data     (op_data),
  .op_is32     (op_is32),
  .op_ready    (op_ready),
  .dbg_mode    (dbg_mode),
  .dbg_enter   (dbg_enter),
  .cause_flags (cause_flags)
);

// File: tb/tb_dbg_entry_inject.sv
module tb_dbg_entry_inject;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        dbg_en = 0, dbg_mask = 0, sw_dbit_wr = 0, flag_clr_we = 0;
  logic [7:0]  cause_evt = 0, flag_clr_mask = 0;
  logic        inj_valid = 0, op_ready = 1;
  logic [31:0] inj_data = 0;
  logic        inj_ready, op_valid, op_is32, dbg_mode, dbg_enter, sr_dbit, inj_done;
  logic [31:0] op_data;
  logic [7:0]  cause_flags;

  dbg_entry_inject dut (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .dbg_mask(dbg_mask),
    .cause_evt(cause_evt), .sw_dbit_wr(sw_dbit_wr), .flag_clr_we(flag_clr_we),
    .flag_clr_mask(flag_clr_mask), .inj_valid(inj_valid), .inj_data(inj_data),
    .inj_ready(inj_ready), .op_valid(op_valid), .op_data(op_data), .op_is32(op_is32),
    .op_ready(op_ready), .dbg_mode(dbg_mode), .dbg_enter(dbg_enter),
    .cause_flags(cause_flags), .sr_dbit(sr_dbit), .inj_done(inj_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit rnd_rdy = 0;

  // reference model state
  bit          m_dbg = 0, m_pulse = 0, m_sr = 0, m_inc = 1, m_hv = 0;
  logic [7:0]  m_flags = 0;
  logic [15:0] m_hold = 0;
  logic [15:0] q[$];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void predict(output bit v, output logic [31:0] d, output bit x, output bit r);
    v = 0; d = '0; x = 0;
    r = m_dbg && (q.size() == 0);
    if (q.size() > 0) begin
      if (m_hv) begin v = 1; x = 1; d = {m_hold, q[0]}; end
      else if (q[0][15:13] == 3'b111) begin
        if (q.size() >= 2) begin v = 1; x = 1; d = {q[0], q[1]}; end
      end else begin v = 1; d = {16'h0, q[0]}; end
    end
  endfunction

  always @(posedge clk) begin
    bit v, x, r, ent, ext, wr, acc;
    logic [31:0] d;
    if (!rst_n) begin
      m_dbg = 0; m_pulse = 0; m_sr = 0; m_inc = 1; m_hv = 0; m_flags = 0; q.delete();
    end else begin
      predict(v, d, x, r);
      acc = v && op_ready;
      wr  = inj_valid && r;
      ext = acc && !x && (d[15:0] == 16'hD623);
      ent = !m_dbg && dbg_en && !dbg_mask && (cause_evt != 0);
      m_flags = (m_flags & ~(flag_clr_we ? flag_clr_mask : 8'h0)) | (ent ? cause_evt : 8'h0);
      m_pulse = ent;
      if (ext) m_sr = 0; else if (ent || sw_dbit_wr) m_sr = 1;
      if (ent) m_dbg = 1; else if (ext) m_dbg = 0;
      if (ext) begin q.delete(); m_hv = 0; end
      else if (wr) begin q.delete(); q.push_back(inj_data[31:16]); q.push_back(inj_data[15:0]); end
      else if (acc) begin
        if (m_hv) begin m_hv = 0; void'(q.pop_front()); end
        else if (x) begin void'(q.pop_front()); void'(q.pop_front()); end
        else void'(q.pop_front());
      end else if (q.size() == 1 && q[0][15:13] == 3'b111 && !m_hv) begin
        m_hold = q[0]; m_hv = 1; void'(q.pop_front());
      end
      if (wr) m_inc = 0; else if (q.size() == 0) m_inc = 1;
    end
  end

  always @(negedge clk) begin
    bit v, x, r;
    logic [31:0] d;
    if (rst_n) begin
      predict(v, d, x, r);
      chk("R1", "dbg_mode", 32'(dbg_mode), 32'(m_dbg));
      chk("R4", "dbg_enter", 32'(dbg_enter), 32'(m_pulse));
      chk("R2", "cause_flags", 32'(cause_flags), 32'(m_flags));
      chk("R5", "sr_dbit", 32'(sr_dbit), 32'(m_sr));
      chk("R7", "inj_done", 32'(inj_done), 32'(m_inc));
      chk("R8", "inj_ready", 32'(inj_ready), 32'(r));
      chk("R6", "op_valid", 32'(op_valid), 32'(v));
      if (v) begin
        chk("R6", "op_data", op_data, d);
        chk("R6", "op_is32", 32'(op_is32), 32'(x));
      end
    end
  end

  task automatic inj_write(input logic [31:0] w);
    @(negedge clk);
    while (!inj_ready) begin
      if (rnd_rdy) op_ready = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    inj_valid = 1; inj_data = w;
    if (rnd_rdy) op_ready = 1'($urandom_range(0, 1));
    @(negedge clk);
    inj_valid = 0;
  endtask

  task automatic pulse_cause(input logic [7:0] c);
    @(negedge clk); cause_evt = c;
    @(negedge clk); cause_evt = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8", "reset inj_ready", 32'(inj_ready), 0);
    chk("R7", "reset inj_done", 32'(inj_done), 1);
    chk("R1", "reset dbg_mode", 32'(dbg_mode), 0);

    // R1: disabled, then masked
    pulse_cause(8'h10);
    chk("R1", "disabled ignored", 32'(dbg_mode), 0);
    chk("R1", "disabled flags", 32'(cause_flags), 0);
    dbg_en = 1; dbg_mask = 1;
    pulse_cause(8'h08);
    chk("R1", "masked ignored", 32'(dbg_mode), 0);
    dbg_mask = 0;

    // R5: software debug bit
    @(negedge clk); sw_dbit_wr = 1;
    @(negedge clk); sw_dbit_wr = 0;
    chk("R5", "sr_dbit set", 32'(sr_dbit), 1);
    chk("R5", "no entry", 32'(dbg_mode), 0);

    // R2/R4: multiple causes at once
    @(negedge clk); cause_evt = 8'h26;
    @(negedge clk); cause_evt = 0;
    chk("R2", "flags multi", 32'(cause_flags), 32'h26);
    chk("R4", "enter pulse", 32'(dbg_enter), 1);
    @(negedge clk);
    chk("R4", "pulse ends", 32'(dbg_enter), 0);
    pulse_cause(8'h80);
    chk("R2", "cause in debug ignored", 32'(cause_flags), 32'h26);

    // R3: write one to clear
    @(negedge clk); flag_clr_we = 1; flag_clr_mask = 8'h06;
    @(negedge clk); flag_clr_we = 0;
    chk("R3", "partial clear", 32'(cause_flags), 32'h20);

    // R6/R7: two compact opcodes
    inj_write(32'h0E9C201C);
    chk("R6", "first parcel", op_data, 32'h00000E9C);
    chk("R7", "done cleared", 32'(inj_done), 0);
    @(negedge clk);
    chk("R6", "second parcel", op_data, 32'h0000201C);
    @(negedge clk);
    chk("R7", "done set", 32'(inj_done), 1);

    // R6: straddling extended opcode, then return
    inj_write(32'h1896F807);
    chk("R6", "compact before half", op_data, 32'h00001896);
    repeat (2) @(negedge clk);
    chk("R7", "done with half held", 32'(inj_done), 1);
    inj_write(32'h0046D623);
    chk("R6", "joined extended", op_data, 32'hF8070046);
    chk("R6", "joined is32", 32'(op_is32), 1);
    @(negedge clk);
    chk("R9", "return offered", op_data, 32'h0000D623);
    @(negedge clk);
    chk("R9", "exited", 32'(dbg_mode), 0);

    // R10: stall on a whole extended opcode
    pulse_cause(8'h81);
    chk("R2", "flags after reentry", 32'(cause_flags), 32'hA1);
    op_ready = 0;
    inj_write(32'hE0001111);
    repeat (3) begin
      @(negedge clk);
      chk("R10", "held valid", 32'(op_valid), 1);
      chk("R10", "held data", op_data, 32'hE0001111);
    end
    op_ready = 1;
    @(negedge clk);
    chk("R7", "done after stall", 32'(inj_done), 1);

    // R9: return then extended half discarded
    inj_write(32'hD623F807);
    @(negedge clk);
    chk("R9", "exit mode", 32'(dbg_mode), 0);
    chk("R9", "no pending op", 32'(op_valid), 0);
    pulse_cause(8'h01);
    inj_write(32'h12340000);
    chk("R9", "no stale half", op_data, 32'h00001234);
    chk("R9", "compact after exit", 32'(op_is32), 0);
    repeat (2) @(negedge clk);

    // random words, random core ready
    rnd_rdy = 1;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 4 == 0) w[15:13] = 3'b111;
      if (w[31:16] == 16'hD623) w[16] = 1'b0;
      if (w[15:0] == 16'hD623) w[0] = 1'b0;
      inj_write(w);
    end
    inj_write(32'hD623D623);
    rnd_rdy = 0; op_ready = 1;
    for (int k = 0; k < 10 && dbg_mode; k++) @(negedge clk);
    chk("R9", "final exit", 32'(dbg_mode), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule